// File: doc/BRIEF.md
# SPI Buffered Status Front End

This block is the register-facing half of an 8-bit SPI peripheral. It holds one transmit holding byte that feeds an external shift engine, one receive byte, a control register and three status flags: transmit room, receive full and a master-mode fault. Software reaches them through a small bus with read and write strobes. Flags change only through read-then-act sequences. A byte written to the data register is taken only if the last status access saw the transmit room flag set.

A four-state machine tracks the transmit side. The states are TX_IDLE (nothing buffered, nothing shifting), TX_HOLD (a byte waits, no transfer), TX_SHIFT (a transfer runs, the holding buffer is free) and TX_SHIFT_HOLD (a transfer runs, a byte waits). Its transitions are:
- **accept**: TX_IDLE to TX_HOLD, and TX_SHIFT to TX_SHIFT_HOLD.
- **launch**: TX_HOLD to TX_SHIFT when master mode is on.
- **finish**: TX_SHIFT to TX_IDLE, or to TX_HOLD when a byte is accepted in the same cycle.
- **chain**: TX_SHIFT_HOLD to TX_SHIFT when master mode is on, otherwise to TX_HOLD.
- **abort**: TX_SHIFT to TX_IDLE, and TX_SHIFT_HOLD to TX_HOLD.

Bit clocking is left to an external shifter. The block starts it with a load pulse, can cancel it with an abort pulse, and takes a done pulse with the received byte.

Top module: `spi_buf_ctrl`

## Requirements
- R1: After reset, the status register (address 0) reads 0x01 and the control register (address 1) reads 0x00. The data register (address 2) reads 0x00, and no load pulse or interrupt is raised. Status bit 0 is transmit room, bit 1 is receive full and bit 2 is mode fault. Control bit 0 is the interrupt enable, bit 1 is master mode, bit 2 is fault detect enable and bit 3 is select-output enable.
- R2: A data write is ignored unless it follows a status read that saw transmit room at 1, with no write to the status or control register in between. An ignored write changes neither the flag nor the shifter.
- R3: In master mode with the block idle, an accepted write clears transmit room for one cycle. On the next edge it issues one load pulse carrying the byte, sets transmit room again and raises busy.
- R4: A byte accepted during a transfer clears transmit room. When the transfer finishes, the byte is loaded in the cycle of the done pulse, and transmit room is 1 afterwards.
- R5: When a transfer finishes with no byte waiting, the block returns to idle with no further load, and transmit room stays 1.
- R6: With master mode off, an accepted byte waits in the holding buffer (transmit room 0, no load). Turning master mode on then starts its transfer.
- R7: A finished transfer stores the received byte and sets receive full. A status read that sees receive full, followed by a data read, returns the byte and clears the flag.
- R8: A transfer that finishes while receive full is 1, and is not read in that cycle, discards its byte. The earlier byte is kept.
- R9: The mode fault flag sets only while select is low with master mode on, fault detect on and select-output off. No other combination sets it.
- R10: A mode fault clears master mode and pulses abort if a transfer runs, which drops busy. A waiting byte stays in the holding buffer.
- R11: The mode fault flag clears only on a control write that follows a status read which saw it at 1.
- R12: The transmit interrupt is high exactly while transmit room and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 status, 1 control, 2 data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| ss_n | input | 1 | Slave select input, active low |
| irq_tx | output | 1 | Transmit room interrupt request |
| shf_load | output | 1 | Starts a transfer with shf_txd |
| shf_txd | output | 8 | Byte handed to the shifter |
| shf_abort | output | 1 | Cancels the running transfer |
| shf_done | input | 1 | Transfer finished |
| shf_rxd | input | 8 | Byte received by the finished transfer |
| xfer_busy | output | 1 | A transfer is running |

## Verification
Data writes are tried unarmed, armed and then cancelled by a control write, armed while idle, armed while a transfer runs, and with master mode off. These patterns separate the arming rule from the launch and chaining paths of the state machine. The shifter model returns the inverse of each byte it loads, so the byte read back shows whether a second completion overwrote the first or was dropped as an overrun. The select input is pulled low under three wrong control combinations and then under the correct one, and fault clearing is tried without and with the arming status read.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
    typedef enum logic [1:0] {
        TX_IDLE,
        TX_HOLD,
        TX_SHIFT,
        TX_SHIFT_HOLD
    } tx_state_e;

    localparam logic [1:0] REG_STATUS = 2'd0;
    localparam logic [1:0] REG_CTRL   = 2'd1;
    localparam logic [1:0] REG_DATA   = 2'd2;

    localparam int CT_IE  = 0;
    localparam int CT_MST = 1;
    localparam int CT_FDE = 2;
    localparam int CT_SSO = 3;
endpackage

// File: rtl/spi_tx_path.sv
module spi_tx_path
    import spi_buf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              master_en,
    input  logic              abort,
    input  logic              shf_done,
    output logic              tx_empty,
    output logic              busy,
    output logic              shf_load,
    output logic [DATA_W-1:0] shf_txd,
    output logic              xfer_done
);
    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // holding buffer, written only on an accepted byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= '0;
        else if (wr_ok) hold_q <= wr_byte;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:       if (wr_ok) state_d = TX_HOLD;
            TX_HOLD:       if (!abort && master_en) state_d = TX_SHIFT;
            TX_SHIFT: begin
                if (abort)         state_d = TX_IDLE;
                else if (shf_done) state_d = wr_ok ? TX_HOLD : TX_IDLE;
                else if (wr_ok)    state_d = TX_SHIFT_HOLD;
            end
            TX_SHIFT_HOLD: begin
                if (abort)         state_d = TX_HOLD;
                else if (shf_done) state_d = master_en ? TX_SHIFT : TX_HOLD;
            end
            default:       state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_empty  = (state_q == TX_IDLE) || (state_q == TX_SHIFT);
        busy      = (state_q == TX_SHIFT) || (state_q == TX_SHIFT_HOLD);
        shf_load  = !abort && master_en &&
                    ((state_q == TX_HOLD) || ((state_q == TX_SHIFT_HOLD) && shf_done));
        xfer_done = busy && shf_done && !abort;
        shf_txd   = hold_q;
    end
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_in,
    input  logic              clr,
    output logic              rx_full,
    output logic [DATA_W-1:0] rx_buf
);
    logic still_full;
    assign still_full = rx_full && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_buf  <= '0;
        end else if (xfer_done && !still_full) begin
            rx_full <= 1'b1;
            rx_buf  <= rx_in;
        end else if (clr) begin
            rx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_buf_ctrl.sv
module spi_buf_ctrl
    import spi_buf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ss_n,
    output logic              irq_tx,
    output logic              shf_load,
    output logic [DATA_W-1:0] shf_txd,
    output logic              shf_abort,
    input  logic              shf_done,
    input  logic [DATA_W-1:0] shf_rxd,
    output logic              xfer_busy
);
    localparam int PAD_W = DATA_W - 3;

    logic [DATA_W-1:0] ctrl_q;
    logic              fault_q;
    logic              tx_arm, rx_arm, flt_arm;
    logic              tx_empty, rx_full, xfer_done;
    logic [DATA_W-1:0] rx_buf;
    logic              rd_st, rd_dat, wr_st, wr_ctl, wr_dat;
    logic              wr_ok, rx_clr, fault_cond;

    assign rd_st  = bus_rd && (bus_addr == REG_STATUS);
    assign rd_dat = bus_rd && (bus_addr == REG_DATA);
    assign wr_st  = bus_wr && (bus_addr == REG_STATUS);
    assign wr_ctl = bus_wr && (bus_addr == REG_CTRL);
    assign wr_dat = bus_wr && (bus_addr == REG_DATA);

    assign fault_cond = ctrl_q[CT_MST] && ctrl_q[CT_FDE] && !ctrl_q[CT_SSO] && !ss_n;
    assign wr_ok      = wr_dat && tx_arm && tx_empty;
    assign rx_clr     = rd_dat && rx_arm && rx_full;

    spi_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_byte(bus_wdata),
        .master_en(ctrl_q[CT_MST]), .abort(fault_cond), .shf_done(shf_done),
        .tx_empty(tx_empty), .busy(xfer_busy), .shf_load(shf_load),
        .shf_txd(shf_txd), .xfer_done(xfer_done)
    );

    spi_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .rx_in(shf_rxd),
        .clr(rx_clr), .rx_full(rx_full), .rx_buf(rx_buf)
    );

    // read-armed markers for the three flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_arm  <= 1'b0;
            rx_arm  <= 1'b0;
            flt_arm <= 1'b0;
        end else if (rd_st) begin
            tx_arm  <= tx_empty;
            rx_arm  <= rx_full;
            flt_arm <= fault_q;
        end else begin
            if (wr_st || wr_ctl || wr_dat) tx_arm  <= 1'b0;
            if (wr_st || wr_ctl || rd_dat) rx_arm  <= 1'b0;
            if (wr_st || wr_ctl || wr_dat) flt_arm <= 1'b0;
        end
    end

    // control register and mode fault flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            if (wr_ctl) ctrl_q <= bus_wdata;
            if (fault_cond) begin
                ctrl_q[CT_MST] <= 1'b0;
                fault_q        <= 1'b1;
            end else if (wr_ctl && flt_arm) begin
                fault_q        <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            REG_STATUS: bus_rdata = {{PAD_W{1'b0}}, fault_q, rx_full, tx_empty};
            REG_CTRL:   bus_rdata = ctrl_q;
            REG_DATA:   bus_rdata = rx_buf;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_tx    = tx_empty && ctrl_q[CT_IE];
    assign shf_abort = fault_cond && xfer_busy;
endmodule

// File: rtl/spi_buf_ctrl_chk.sv
module spi_buf_ctrl_chk
    import spi_buf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              fault_q,
    input logic              ct_ie,
    input logic              ct_mst,
    input logic              ct_fde,
    input logic              ct_sso,
    input logic              ss_n,
    input logic              shf_load,
    input logic              irq_tx,
    input logic [DATA_W-1:0] rx_buf,
    input logic              bus_rd,
    input logic [1:0]        bus_addr
);
    AST_LOAD_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        shf_load |-> ct_mst); // R6
    AST_ROOM_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        shf_load |=> tx_empty); // R3
    AST_FAULT_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> $past(ct_mst && ct_fde && !ct_sso && !ss_n)); // R9
    AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> !ct_mst); // R10
    AST_OVERRUN_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && $past(rx_full) && !$past(bus_rd && (bus_addr == REG_DATA)))
        |-> $stable(rx_buf)); // R8
    AST_IRQ_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (tx_empty && ct_ie)); // R12
endmodule

bind spi_buf_ctrl spi_buf_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .rx_full(rx_full),
    .fault_q(fault_q), .ct_ie(ctrl_q[0]), .ct_mst(ctrl_q[1]),
    .ct_fde(ctrl_q[2]), .ct_sso(ctrl_q[3]), .ss_n(ss_n),
    .shf_load(shf_load), .irq_tx(irq_tx), .rx_buf(rx_buf),
    .bus_rd(bus_rd), .bus_addr(bus_addr)
);

// File: tb/spi_buf_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_buf_ctrl_tb_top;
    localparam int XFER_LEN = 8;
    localparam logic [1:0] A_ST = 2'd0, A_CT = 2'd1, A_DT = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       ss_n = 1'b1;
    logic       irq_tx, shf_load, shf_abort, shf_done, xfer_busy;
    logic [7:0] shf_txd, shf_rxd;

    int errors = 0, checks = 0;
    int load_cnt = 0, abort_cnt = 0, cnt = 0;
    logic [7:0] last_load = '0, rx_model = '0;

    always #10 clk = ~clk;

    spi_buf_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ss_n(ss_n), .irq_tx(irq_tx), .shf_load(shf_load), .shf_txd(shf_txd),
        .shf_abort(shf_abort), .shf_done(shf_done), .shf_rxd(shf_rxd),
        .xfer_busy(xfer_busy)
    );

    // abstract shifter: fixed length, returns the inverse of the loaded byte
    assign shf_done = (cnt == 1);
    assign shf_rxd  = rx_model;
    always @(posedge clk) begin
        if (shf_abort) begin
            cnt <= 0;
            abort_cnt <= abort_cnt + 1;
        end else if (shf_load) begin
            cnt <= XFER_LEN;
            rx_model <= ~shf_txd;
            last_load <= shf_txd;
            load_cnt <= load_cnt + 1;
        end else if (cnt > 0) begin
            cnt <= cnt - 1;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        peek(A_ST, d); chk("R1 status", d, 8'h01);
        peek(A_CT, d); chk("R1 control", d, 8'h00);
        peek(A_DT, d); chk("R1 data", d, 8'h00);
        chk("R1 irq", {7'd0, irq_tx}, 8'h00);
        chk("R1 loads", load_cnt[7:0], 8'd0);
    endtask

    task automatic t_unarmed;
        logic [7:0] d;
        wr(A_CT, 8'h02);
        wr(A_DT, 8'hA5);
        idle(2);
        peek(A_ST, d); chk("R2 unarmed write keeps room", d, 8'h01);
        chk("R2 unarmed write no load", load_cnt[7:0], 8'd0);
        rd(A_ST, d);
        wr(A_CT, 8'h02);
        wr(A_DT, 8'hA6);
        idle(2);
        peek(A_ST, d); chk("R2 disarmed by control write", d, 8'h01);
        chk("R2 disarmed no load", load_cnt[7:0], 8'd0);
    endtask

    task automatic t_idle_write;
        logic [7:0] d;
        rd(A_ST, d);
        wr(A_DT, 8'h3C);
        peek(A_ST, d); chk("R3 room cleared", d & 8'h01, 8'h00);
        idle(1);
        peek(A_ST, d); chk("R3 room back", d & 8'h01, 8'h01);
        chk("R3 one load", load_cnt[7:0], 8'd1);
        chk("R3 load byte", last_load, 8'h3C);
        chk("R3 busy", {7'd0, xfer_busy}, 8'h01);
        idle(12);
        chk("R5 idle after done", {7'd0, xfer_busy}, 8'h00);
        peek(A_ST, d); chk("R7 receive full", d, 8'h03);
        rd(A_ST, d);
        rd(A_DT, d); chk("R7 received byte", d, 8'hC3);
        peek(A_ST, d); chk("R7 full cleared", d, 8'h01);
    endtask

    task automatic t_queued;
        logic [7:0] d;
        int base;
        base = load_cnt;
        rd(A_ST, d);
        wr(A_DT, 8'h11);
        idle(1);
        rd(A_ST, d);
        wr(A_DT, 8'h22);
        peek(A_ST, d); chk("R4 room cleared while shifting", d & 8'h01, 8'h00);
        idle(30);
        chk("R4 chained load count", 8'(load_cnt - base), 8'd2);
        chk("R4 chained byte", last_load, 8'h22);
        chk("R5 no extra load, idle", {7'd0, xfer_busy}, 8'h00);
        peek(A_ST, d); chk("R5 room set, full set", d, 8'h03);
        peek(A_DT, d); chk("R8 overrun keeps first byte", d, 8'hEE);
        rd(A_ST, d);
        rd(A_DT, d);
    endtask

    task automatic t_slave;
        logic [7:0] d;
        int base;
        base = load_cnt;
        wr(A_CT, 8'h00);
        rd(A_ST, d);
        wr(A_DT, 8'h44);
        idle(3);
        peek(A_ST, d); chk("R6 byte waits", d, 8'h00);
        chk("R6 no load", 8'(load_cnt - base), 8'd0);
        wr(A_CT, 8'h02);
        idle(2);
        chk("R6 load on master", 8'(load_cnt - base), 8'd1);
        chk("R6 load byte", last_load, 8'h44);
        idle(12);
        rd(A_ST, d);
        rd(A_DT, d); chk("R6 received", d, 8'hBB);
    endtask

    task automatic t_fault;
        logic [7:0] d;
        int base;
        wr(A_CT, 8'h0E); ss_n = 1'b0; idle(3);
        peek(A_ST, d); chk("R9 no fault with select output", d, 8'h01);
        wr(A_CT, 8'h04); idle(3);
        peek(A_ST, d); chk("R9 no fault without master", d, 8'h01);
        wr(A_CT, 8'h02); idle(3);
        peek(A_ST, d); chk("R9 no fault without detect", d, 8'h01);
        chk("R9 no abort", abort_cnt[7:0], 8'd0);
        ss_n = 1'b1;
        wr(A_CT, 8'h06);
        base = load_cnt;
        rd(A_ST, d);
        wr(A_DT, 8'h55);
        idle(1);
        rd(A_ST, d);
        wr(A_DT, 8'h66);
        ss_n = 1'b0;
        idle(2);
        chk("R10 abort pulsed", abort_cnt[7:0], 8'd1);
        peek(A_ST, d); chk("R9 fault set, byte held", d, 8'h04);
        peek(A_CT, d); chk("R10 master cleared", d, 8'h04);
        chk("R10 busy dropped", {7'd0, xfer_busy}, 8'h00);
        chk("R10 no reload", 8'(load_cnt - base), 8'd1);
        ss_n = 1'b1;
        wr(A_CT, 8'h04); idle(1);
        peek(A_ST, d); chk("R11 unarmed control write keeps fault", d, 8'h04);
        rd(A_ST, d);
        wr(A_CT, 8'h06);
        idle(2);
        peek(A_ST, d); chk("R11 fault cleared", d & 8'h04, 8'h00);
        chk("R10 held byte sent", last_load, 8'h66);
        idle(12);
        rd(A_ST, d);
        rd(A_DT, d); chk("R10 held byte received", d, 8'h99);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        wr(A_CT, 8'h01); idle(1);
        chk("R12 irq with room", {7'd0, irq_tx}, 8'h01);
        rd(A_ST, d);
        wr(A_DT, 8'h12); idle(1);
        chk("R12 irq off when full", {7'd0, irq_tx}, 8'h00);
        wr(A_CT, 8'h03); idle(2);
        chk("R12 irq back after load", {7'd0, irq_tx}, 8'h01);
        chk("R12 loaded byte", last_load, 8'h12);
        wr(A_CT, 8'h02); idle(1);
        chk("R12 irq off when disabled", {7'd0, irq_tx}, 8'h00);
        idle(12);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_unarmed;
        t_idle_write;
        t_queued;
        t_slave;
        t_fault;
        t_irq;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule